// File: doc/BRIEF.md
# Flash Block Lock Range Controller

This block keeps the write-protection state of every erase block in a flash array of `NUM_BLOCKS` blocks, where `NUM_BLOCKS` is a power of two. Each block is in one of three states, held one-hot: unlocked, locked, or lock-tight. The host first sets a block range with two address registers. It then writes a command code that tells the controller to unlock, lock or lock-tight that range. The controller walks the range one block per clock. It updates each block it is allowed to change and copies the newest state into a write-protection status register.

When a walk ends, the block gives a one-cycle done pulse and sets a sticky interrupt flag. Software clears that flag with an acknowledge write. Command writes are ignored while a walk is running or while the interrupt flag is set. A command code that is not recognised raises a sticky command error. A read port lets any block's current state be read at any time.

Top module: `lock_range_ctrl`

## Requirements
- R1: After reset every block reads locked (`3'b010`), `wpStatus` is `16'h0002`, and `busy`, `done`, `intFlag` and `cmdErr` are all 0. The state encoding is bit 0 = lock-tight, bit 1 = locked, bit 2 = unlocked.
- R2: A register write with `regSel`=0 (range start) keeps `regData` masked to `NUM_BLOCKS-1` as the start and copies the same masked value into the range end. A write with `regSel`=1 (range end) sets only the end, masked the same way.
- R3: A command write (`regSel`=2) of `16'h0023` (unlock) or `16'h002A` (lock) sets every block from start to end, end included, to unlocked or locked. If start is greater than end, no block changes.
- R4: An unlock or lock walk stops at the first lock-tight block it meets, without error. That block and every block after it are left unchanged.
- R5: A command `16'h002C` (lock-tight) walks the whole range. It leaves unlocked blocks as they are and sets every other block to lock-tight.
- R6: Each block that a walk changes loads its new state into `wpStatus[2:0]`, with the upper bits zero. Blocks that are skipped or not reached do not change `wpStatus`.
- R7: A walk visits one block per clock. `done` pulses for one cycle m cycles after the clock edge that takes the command, where m is the number of blocks visited, the stopping lock-tight block included (m = 1 for an empty range). `busy` is high from that edge until the pulse.
- R8: `intFlag` is set together with every `done` pulse. A command write is ignored while `busy` or `intFlag` is high. An acknowledge write (`regSel`=3) clears `intFlag` and `cmdErr`.
- R9: Any other command code sets `cmdErr` and gives a `done` pulse one cycle after it is taken (m = 0). No block and no `wpStatus` bit changes.
- R10: `rdState` is always exactly one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 start, 1 end, 2 command, 3 acknowledge |
| regData | input | 16 | Register write data |
| busy | output | 1 | A range walk is in progress |
| done | output | 1 | One-cycle pulse when a command finishes |
| intFlag | output | 1 | Sticky interrupt flag, cleared by acknowledge |
| cmdErr | output | 1 | Sticky command error, cleared by acknowledge |
| wpStatus | output | 16 | Write-protection status: state of the last changed block |
| rdIdx | input | $clog2(NUM_BLOCKS) | Block index for the state read port |
| rdState | output | 3 | One-hot state of block `rdIdx` |

## Verification
The assertions assume that `regWe` is a clean one-cycle strobe and that an acknowledge is never written in the same cycle that a walk finishes. The property that says no walk can start while the flag is pending also depends on that. The stimulus keeps to these assumptions by writing one register per cycle. It waits for `done` before it acknowledges, and it sends the ignored commands only while a walk is running or before the acknowledge. The range values are chosen so that walks run into lock-tight blocks, skip unlocked blocks, cover empty ranges, and use addresses that need masking.

// File: rtl/lock_range_pkg.sv
package lock_range_pkg;

  // one-hot block protection states
  localparam logic [2:0] LS_TIGHT    = 3'b001;
  localparam logic [2:0] LS_LOCKED   = 3'b010;
  localparam logic [2:0] LS_UNLOCKED = 3'b100;

  // command codes
  localparam logic [15:0] OP_UNLOCK = 16'h0023;
  localparam logic [15:0] OP_LOCK   = 16'h002A;
  localparam logic [15:0] OP_TIGHT  = 16'h002C;

  // register selects
  localparam logic [1:0] SEL_START = 2'd0;
  localparam logic [1:0] SEL_END   = 2'd1;
  localparam logic [1:0] SEL_CMD   = 2'd2;
  localparam logic [1:0] SEL_ACK   = 2'd3;

  typedef enum logic [1:0] {WALK_UNLOCK, WALK_LOCK, WALK_TIGHT} walkOp_t;

  // strobes from the walk control to the block store
  typedef struct packed {
    logic beginWalk;
    logic writeBlk;
    logic advance;
  } walkStrobe_t;

endpackage

// File: rtl/lock_range_walker.sv
module lock_range_walker
  import lock_range_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWe,
  input  logic        ackWe,
  input  logic [15:0] cmdCode,
  input  logic [2:0]  curState,
  input  logic        atEnd,
  input  logic        beyondEnd,
  input  logic        outRange,
  output walkStrobe_t strobe,
  output walkOp_t     walkOp,
  output logic        busy,
  output logic        done,
  output logic        intFlag,
  output logic        cmdErr
);

  logic    accept;
  logic    knownOp;
  logic    badCmd;
  logic    finish;
  logic    errSet;
  walkOp_t decodedOp;

  always_comb begin
    knownOp   = 1'b1;
    decodedOp = WALK_LOCK;
    case (cmdCode)
      OP_UNLOCK: decodedOp = WALK_UNLOCK;
      OP_LOCK:   decodedOp = WALK_LOCK;
      OP_TIGHT:  decodedOp = WALK_TIGHT;
      default:   knownOp   = 1'b0;
    endcase
  end

  assign accept = cmdWe && !busy && !intFlag;
  assign badCmd = accept && !knownOp;

  // one block per clock: decide whether to change it, move on, or stop
  always_comb begin
    strobe           = '0;
    finish           = 1'b0;
    errSet           = 1'b0;
    strobe.beginWalk = accept && knownOp;
    if (busy) begin
      if (outRange) begin
        finish = 1'b1;
        errSet = 1'b1;
      end else if (beyondEnd) begin
        finish = 1'b1;
      end else if (walkOp != WALK_TIGHT && curState == LS_TIGHT) begin
        finish = 1'b1;
      end else begin
        strobe.writeBlk = !(walkOp == WALK_TIGHT && curState == LS_UNLOCKED);
        if (atEnd) finish = 1'b1;
        else       strobe.advance = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      intFlag <= 1'b0;
      cmdErr  <= 1'b0;
      walkOp  <= WALK_LOCK;
    end else begin
      done <= finish || badCmd;
      if (strobe.beginWalk) begin
        busy   <= 1'b1;
        walkOp <= decodedOp;
      end else if (finish) begin
        busy <= 1'b0;
      end
      if (finish || badCmd) intFlag <= 1'b1;
      else if (ackWe)       intFlag <= 1'b0;
      if (errSet || badCmd) cmdErr <= 1'b1;
      else if (ackWe)       cmdErr <= 1'b0;
    end
  end

endmodule

// File: rtl/lock_range_store.sv
module lock_range_store
  import lock_range_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  localparam int IDX_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startWe,
  input  logic             endWe,
  input  logic [IDX_W-1:0] addrIn,
  input  walkStrobe_t      strobe,
  input  walkOp_t          walkOp,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [2:0]       curState,
  output logic             atEnd,
  output logic             beyondEnd,
  output logic             outRange,
  output logic [2:0]       rdState,
  output logic [15:0]      wpStatus
);

  logic [IDX_W-1:0] startReg;
  logic [IDX_W-1:0] endReg;
  logic [IDX_W-1:0] walkEnd;
  logic [IDX_W:0]   walkIdx;
  logic [2:0]       newState;
  logic [2:0]       blkState [NUM_BLOCKS];

  always_comb begin
    case (walkOp)
      WALK_UNLOCK: newState = LS_UNLOCKED;
      WALK_TIGHT:  newState = LS_TIGHT;
      default:     newState = LS_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startReg <= '0;
      endReg   <= '0;
      walkEnd  <= '0;
      walkIdx  <= '0;
      wpStatus <= {13'd0, LS_LOCKED};
    end else begin
      if (startWe) begin
        startReg <= addrIn;
        endReg   <= addrIn;
      end else if (endWe) begin
        endReg <= addrIn;
      end
      if (strobe.beginWalk) begin
        walkIdx <= {1'b0, startReg};
        walkEnd <= endReg;
      end else if (strobe.advance) begin
        walkIdx <= walkIdx + 1'b1;
      end
      if (strobe.writeBlk) wpStatus <= {13'd0, newState};
    end
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) blkState[b] <= LS_LOCKED;
      else if (strobe.writeBlk && walkIdx == (IDX_W + 1)'(b))
        blkState[b] <= newState;
    end
  end

  assign curState  = blkState[walkIdx[IDX_W-1:0]];
  assign rdState   = blkState[rdIdx];
  assign atEnd     = walkIdx == {1'b0, walkEnd};
  assign beyondEnd = walkIdx > {1'b0, walkEnd};
  assign outRange  = walkIdx[IDX_W];

endmodule

// File: rtl/lock_range_ctrl.sv
module lock_range_ctrl
  import lock_range_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  localparam int IDX_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regSel,
  input  logic [15:0]      regData,
  output logic             busy,
  output logic             done,
  output logic             intFlag,
  output logic             cmdErr,
  output logic [15:0]      wpStatus,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [2:0]       rdState
);

  walkStrobe_t strobe;
  walkOp_t     walkOp;
  logic [2:0]  curState;
  logic        atEnd;
  logic        beyondEnd;
  logic        outRange;

  lock_range_walker u_walker (
    .clk       (clk),
    .rstN      (rstN),
    .cmdWe     (regWe && regSel == SEL_CMD),
    .ackWe     (regWe && regSel == SEL_ACK),
    .cmdCode   (regData),
    .curState  (curState),
    .atEnd     (atEnd),
    .beyondEnd (beyondEnd),
    .outRange  (outRange),
    .strobe    (strobe),
    .walkOp    (walkOp),
    .busy      (busy),
    .done      (done),
    .intFlag   (intFlag),
    .cmdErr    (cmdErr)
  );

  lock_range_store #(.NUM_BLOCKS(NUM_BLOCKS)) u_store (
    .clk       (clk),
    .rstN      (rstN),
    .startWe   (regWe && regSel == SEL_START),
    .endWe     (regWe && regSel == SEL_END),
    .addrIn    (regData[IDX_W-1:0]),
    .strobe    (strobe),
    .walkOp    (walkOp),
    .rdIdx     (rdIdx),
    .curState  (curState),
    .atEnd     (atEnd),
    .beyondEnd (beyondEnd),
    .outRange  (outRange),
    .rdState   (rdState),
    .wpStatus  (wpStatus)
  );

endmodule

// File: rtl/lock_range_checker.sv
module lock_range_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [1:0]  regSel,
  input logic        busy,
  input logic        done,
  input logic        intFlag,
  input logic        cmdErr,
  input logic [15:0] wpStatus,
  input logic [2:0]  rdState
);

  // R7: done lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: busy only drops together with the done pulse
  a_r7_busy_ends_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R8: interrupt flag accompanies every done pulse
  a_r8_int_with_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> intFlag);

  // R8: no walk starts while the interrupt flag is pending
  a_r8_no_start_pending: assert property (@(posedge clk) disable iff (!rstN)
    (intFlag && !busy && !(regWe && regSel == 2'd3)) |=> !busy);

  // R9: a raised command error comes with the interrupt flag
  a_r9_err_has_int: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdErr) |-> intFlag);

  // R6: status always carries one valid one-hot state
  a_r6_wp_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(wpStatus[2:0]) && wpStatus[15:3] == 13'd0);

  // R10: block read port is one-hot
  a_r10_read_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(rdState));

endmodule

bind lock_range_ctrl lock_range_checker u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .regWe    (regWe),
  .regSel   (regSel),
  .busy     (busy),
  .done     (done),
  .intFlag  (intFlag),
  .cmdErr   (cmdErr),
  .wpStatus (wpStatus),
  .rdState  (rdState)
);

// File: tb/tb_lock_range_ctrl.sv
module tb_lock_range_ctrl;

  localparam int N     = 16;
  localparam int IDX_W = $clog2(N);
  localparam logic [2:0] S_TIGHT = 3'b001, S_LOCKED = 3'b010, S_UNL = 3'b100;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWe = 1'b0;
  logic [1:0]       regSel = 2'd0;
  logic [15:0]      regData = 16'd0;
  logic             busy, done, intFlag, cmdErr;
  logic [15:0]      wpStatus;
  logic [IDX_W-1:0] rdIdx = '0;
  logic [2:0]       rdState;

  lock_range_ctrl #(.NUM_BLOCKS(N)) dut (.*);

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    string       tag;
    int          expCyc;
    logic [15:0] wp;
    logic        err;
  } expItem_t;

  expItem_t    sbQ[$];
  logic [2:0]  model [N];
  logic [15:0] modelWp;
  int          curStart, curEnd;

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each done pulse
  always @(negedge clk) begin
    if (rstN && done) begin
      if (sbQ.size() == 0) begin
        check("R7 unexpected done", 1'b0, cyc, -1);
      end else begin
        expItem_t it;
        it = sbQ.pop_front();
        check({it.tag, " done timing"}, cyc == it.expCyc, cyc, it.expCyc);
        check({it.tag, " wpStatus"}, wpStatus == it.wp, wpStatus, it.wp);
        check({it.tag, " cmdErr"}, cmdErr == it.err, cmdErr, it.err);
        check("R8 intFlag with done", intFlag == 1'b1, intFlag, 1);
      end
    end
  end

  task automatic writeReg(input logic [1:0] sel, input logic [15:0] val);
    regWe = 1'b1; regSel = sel; regData = val;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic setStart(input int v);
    writeReg(2'd0, 16'(v));
    curStart = v % N; curEnd = v % N;
  endtask

  task automatic setEnd(input int v);
    writeReg(2'd1, 16'(v));
    curEnd = v % N;
  endtask

  // reference walk from the requirements; returns blocks visited
  task automatic modelWalk(input logic [15:0] op, output int m, output bit bad);
    logic [2:0] ns;
    m = 0; bad = 1'b0;
    if (op == 16'h0023)      ns = S_UNL;
    else if (op == 16'h002A) ns = S_LOCKED;
    else if (op == 16'h002C) ns = S_TIGHT;
    else begin bad = 1'b1; return; end
    if (curStart > curEnd) begin m = 1; return; end
    for (int b = curStart; b <= curEnd; b++) begin
      m++;
      if (op != 16'h002C && model[b] == S_TIGHT) break;
      if (op == 16'h002C && model[b] == S_UNL) continue;
      model[b] = ns;
      modelWp  = {13'd0, ns};
    end
  endtask

  task automatic checkBlocks(input string tag);
    for (int b = 0; b < N; b++) begin
      rdIdx = IDX_W'(b);
      #1;
      check({tag, " block state"}, rdState == model[b], rdState, model[b]);
    end
  endtask

  // driver: optionally pokes a second command while the walk runs
  task automatic issue(input string tag, input logic [15:0] op, input bit poke);
    int m; bit bad; expItem_t it;
    modelWalk(op, m, bad);
    it.tag = tag; it.expCyc = cyc + 1 + m; it.wp = modelWp; it.err = bad;
    sbQ.push_back(it);
    writeReg(2'd2, op);
    if (poke) begin
      check("R8 busy during walk", busy == 1'b1, busy, 1);
      writeReg(2'd2, 16'h002A);
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    checkBlocks(tag);
  endtask

  task automatic ack();
    writeReg(2'd3, 16'd0);
    check("R8 ack clears intFlag", intFlag == 1'b0, intFlag, 0);
    check("R8 ack clears cmdErr", cmdErr == 1'b0, cmdErr, 0);
  endtask

  initial begin
    for (int b = 0; b < N; b++) model[b] = S_LOCKED;
    modelWp = 16'h0002;
    curStart = 0; curEnd = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkBlocks("R1");
    check("R1 wpStatus", wpStatus == 16'h0002, wpStatus, 16'h0002);
    check("R1 flags", {busy, done, intFlag, cmdErr} == 4'b0, {busy, done, intFlag, cmdErr}, 0);

    // R2 start masked and copied into end
    setStart(N + 3);
    issue("R2 masked start", 16'h0023, 1'b0);
    ack();

    // R3 unlock a range, with a second command ignored mid-walk (R8)
    setStart(0); setEnd(7);
    issue("R3 R8 unlock 0..7 poke", 16'h0023, 1'b1);
    ack();

    // R3 lock with masked end (R2)
    setStart(4); setEnd(N + 5);
    issue("R3 R2 lock 4..5", 16'h002A, 1'b0);
    ack();

    // R5 lock-tight skips unlocked blocks
    setStart(2); setEnd(9);
    issue("R5 R6 tighten 2..9", 16'h002C, 1'b0);
    ack();

    // R4 unlock stops at first lock-tight block
    setStart(0); setEnd(N - 1);
    issue("R4 unlock stops", 16'h0023, 1'b0);
    ack();

    // R4 lock stops at tight block 8
    setStart(6); setEnd(12);
    issue("R4 lock stops", 16'h002A, 1'b0);
    ack();

    // R3 empty range: start greater than end
    setStart(10); setEnd(9);
    issue("R3 empty range", 16'h0023, 1'b0);

    // R8 command while intFlag pending is ignored
    writeReg(2'd2, 16'h002A);
    repeat (3) @(negedge clk);
    check("R8 ignored while pending", busy == 1'b0, busy, 0);
    checkBlocks("R8 pending");
    ack();

    // R9 unknown command
    issue("R9 unknown code", 16'h0055, 1'b0);
    check("R9 cmdErr set", cmdErr == 1'b1, cmdErr, 1);
    ack();

    // R3 last block alone
    setStart(N - 1);
    issue("R3 last block", 16'h0023, 1'b0);
    ack();

    repeat (3) @(negedge clk);
    check("R7 scoreboard drained", sbQ.size() == 0, sbQ.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule